// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block is the request and priority core of an eight-input interrupt controller. It captures requests on each line as edge- or level-triggered, according to a per-line trigger vector. It keeps request, in-service, mask and rotation-offset registers. From this state it works out which unmasked request should go to the processor.

Priority is relative to a rotation offset: priority slot 0 belongs to line `offset`, slot 1 to line `offset+1`, and so on, modulo the line count. A request is only raised when its slot outranks the best line already in service. On the master instance, an optional nested mode leaves the cascade line out of that in-service ranking.

An acknowledge strobe takes the current winner. It marks the winner in service, or does not when automatic end-of-interrupt is on. It drops the winner's latched request if the line is edge-triggered. When automatic end-of-interrupt and rotation are both enabled, the acknowledge moves the offset past the acknowledged line. Command decoding, bus access and cascading are handled elsewhere.

Top module: `irq_resolver`

## Requirements
- R1: Synchronous reset clears the request, in-service, mask, previous-level and offset registers, so `irqPending` is 0 and `winLine` is 0 in the cycle after reset.
- R2: For a line whose `trigLevel` bit is 0 (edge mode), the request bit is set on the clock edge after the input is seen high while its stored previous level was low. A held-high input sets it only once, and a falling input leaves the request bit alone.
- R3: For a line whose `trigLevel` bit is 1 (level mode), the request bit copies the input on every clock edge.
- R4: `maskData` bit i masks line i. A pulse on `maskWr` loads it on the next edge, and a masked line never becomes the winner.
- R5: Slot p maps to line (p + offset) mod 8, and slot 0 ranks highest. A pulse on `offsetWr` loads `offsetData` on the next edge. `winLine` reports the line of the best unmasked request, and reads 0 when nothing is pending.
- R6: `irqPending` is 1 only when the best request slot is strictly smaller than the best in-service slot. An equal or lower slot is held off.
- R7: With `nestedMode` set on the master instance, the in-service bit of line 2 is left out of the in-service ranking.
- R8: `ackIn` while pending sets the winner's in-service bit when `autoEoi` is 0. It clears the winner's request bit for edge lines only, and a level line stays requested.
- R9: With `autoEoi` set, an acknowledge leaves the in-service register unchanged. If `rotateOnAeoi` is also set, the offset becomes (winner + 1) mod 8, and this takes precedence over `offsetWr` in the same cycle.
- R10: `ackIn` while nothing is pending changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqIn | input | 8 | Interrupt request lines |
| trigLevel | input | 8 | Per-line trigger mode, 1 = level, 0 = edge |
| maskWr | input | 1 | Load strobe for the mask register |
| maskData | input | 8 | New mask value, 1 = line masked |
| offsetWr | input | 1 | Load strobe for the rotation offset |
| offsetData | input | 3 | New rotation offset |
| autoEoi | input | 1 | Automatic end-of-interrupt on acknowledge |
| rotateOnAeoi | input | 1 | Rotate the offset on automatic end-of-interrupt |
| nestedMode | input | 1 | Exclude the cascade line from in-service ranking |
| ackIn | input | 1 | Acknowledge strobe for the current winner |
| irqPending | output | 1 | An unmasked request outranks everything in service |
| winLine | output | 3 | Line number of the winning request |

## Verification
The bench builds the block with its defaults: eight lines, master instance, cascade on line 2. With these values the slot-to-line mapping wraps past line 7 back to line 0, and the nested-mode exclusion of line 2 can be reached. Directed cases cover the following:
- edge re-arming;
- level persistence across acknowledges;
- equal-slot hold-off;
- rotation on automatic end-of-interrupt.

Seeded random traffic then mixes resets, mask and offset loads and mode changes with acknowledges, and compares every cycle against a model in the bench.

// File: rtl/irq_resolver_pkg.sv
package irq_resolver_pkg;
  // Strobes from the control to the datapath for one clock edge.
  typedef struct packed {
    logic ackFire;   // acknowledge taken on the current winner
    logic setIsr;    // mark winner in service
    logic rotate;    // move offset past the winner
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_resolver_datapath.sv
module irq_resolver_datapath
  import irq_resolver_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] reqIn,
  input  logic [NUM_LINES-1:0] trigLevel,
  input  logic                 maskWr,
  input  logic [NUM_LINES-1:0] maskData,
  input  logic                 offsetWr,
  input  logic [IDX_W-1:0]     offsetData,
  input  ctrlStrobe_t          ctrl,
  input  logic [IDX_W-1:0]     ackLine,
  output logic [NUM_LINES-1:0] irrQ,
  output logic [NUM_LINES-1:0] isrQ,
  output logic [NUM_LINES-1:0] maskQ,
  output logic [IDX_W-1:0]     offsetQ
);
  logic [NUM_LINES-1:0] prevQ;
  logic [NUM_LINES-1:0] riseVec, ackOneHot, irrNext, isrNext, maskNext;
  logic [IDX_W-1:0]     offsetNext;

  always_comb begin
    riseVec    = reqIn & ~prevQ;
    ackOneHot  = ctrl.ackFire ? (NUM_LINES'(1) << ackLine) : '0;
    // level lines copy input; edge lines hold, drop on ack, set on rise
    irrNext    = (trigLevel & reqIn) |
                 (~trigLevel & ((irrQ & ~ackOneHot) | riseVec));
    isrNext    = ctrl.setIsr ? (isrQ | ackOneHot) : isrQ;
    maskNext   = maskWr ? maskData : maskQ;
    if (ctrl.rotate)  offsetNext = IDX_W'(ackLine + 1'b1);
    else if (offsetWr) offsetNext = offsetData;
    else               offsetNext = offsetQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevQ   <= '0;
      irrQ    <= '0;
      isrQ    <= '0;
      maskQ   <= '0;
      offsetQ <= '0;
    end else begin
      prevQ   <= reqIn;
      irrQ    <= irrNext;
      isrQ    <= isrNext;
      maskQ   <= maskNext;
      offsetQ <= offsetNext;
    end
  end

  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((irrQ & $past(trigLevel)) == ($past(reqIn) & $past(trigLevel)))); // R3
  AST_EDGE_ONLY_RISE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((irrQ & ~$past(irrQ) & ~$past(trigLevel) &
                      ~($past(reqIn) & ~$past(prevQ))) == '0)); // R2
  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (rst)
    ctrl.setIsr |=> isrQ[$past(ackLine)]); // R8
  AST_AEOI_ROTATE: assert property (@(posedge clk) disable iff (rst)
    ctrl.rotate |=> (offsetQ == IDX_W'($past(ackLine) + 1'b1))); // R9
  AST_AEOI_KEEPS_ISR: assert property (@(posedge clk) disable iff (rst)
    (ctrl.ackFire && !ctrl.setIsr) |=> $stable(isrQ)); // R9
endmodule

// File: rtl/irq_resolver_control.sv
module irq_resolver_control
  import irq_resolver_pkg::*;
#(
  parameter int NUM_LINES    = 8,
  parameter bit IS_MASTER    = 1'b1,
  parameter int CASCADE_LINE = 2,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irrQ,
  input  logic [NUM_LINES-1:0] isrQ,
  input  logic [NUM_LINES-1:0] maskQ,
  input  logic [IDX_W-1:0]     offsetQ,
  input  logic                 autoEoi,
  input  logic                 rotateOnAeoi,
  input  logic                 nestedMode,
  input  logic                 ackIn,
  output logic                 irqPending,
  output logic [IDX_W-1:0]     winLine,
  output ctrlStrobe_t          ctrl
);
  localparam logic [NUM_LINES-1:0] CASC_BIT = NUM_LINES'(1) << CASCADE_LINE;

  logic [NUM_LINES-1:0] candVec, isrView, rotReq, rotIsr;
  logic [IDX_W:0]       reqSlot, isrSlot;

  // lowest set position, NUM_LINES when empty
  function automatic logic [IDX_W:0] firstSlot(input logic [NUM_LINES-1:0] v);
    logic [IDX_W:0] s;
    s = (IDX_W+1)'(NUM_LINES);
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (v[i]) s = (IDX_W+1)'(i);
    return s;
  endfunction

  generate
    if (IS_MASTER) begin : g_master
      assign isrView = nestedMode ? (isrQ & ~CASC_BIT) : isrQ;
    end else begin : g_slave
      assign isrView = isrQ;
    end
  endgenerate

  always_comb begin
    candVec = irrQ & ~maskQ;
    for (int p = 0; p < NUM_LINES; p++) begin
      rotReq[p] = candVec[IDX_W'(p) + offsetQ];
      rotIsr[p] = isrView[IDX_W'(p) + offsetQ];
    end
    reqSlot    = firstSlot(rotReq);
    isrSlot    = firstSlot(rotIsr);
    irqPending = !reqSlot[IDX_W] && (reqSlot < isrSlot);
    winLine    = irqPending ? (reqSlot[IDX_W-1:0] + offsetQ) : '0;
    ctrl.ackFire = ackIn && irqPending;
    ctrl.setIsr  = ctrl.ackFire && !autoEoi;
    ctrl.rotate  = ctrl.ackFire && autoEoi && rotateOnAeoi;
  end

  AST_WIN_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    irqPending |-> (irrQ[winLine] && !maskQ[winLine])); // R4
  AST_WIN_OUTRANKS: assert property (@(posedge clk) disable iff (rst)
    irqPending |-> !isrView[winLine]); // R6
  AST_IDLE_LINE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !irqPending |-> (winLine == '0)); // R5
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_resolver_pkg::*;
#(
  parameter int NUM_LINES    = 8,
  parameter bit IS_MASTER    = 1'b1,
  parameter int CASCADE_LINE = 2,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] reqIn,
  input  logic [NUM_LINES-1:0] trigLevel,
  input  logic                 maskWr,
  input  logic [NUM_LINES-1:0] maskData,
  input  logic                 offsetWr,
  input  logic [IDX_W-1:0]     offsetData,
  input  logic                 autoEoi,
  input  logic                 rotateOnAeoi,
  input  logic                 nestedMode,
  input  logic                 ackIn,
  output logic                 irqPending,
  output logic [IDX_W-1:0]     winLine
);
  ctrlStrobe_t          ctrl;
  logic [NUM_LINES-1:0] irrQ, isrQ, maskQ;
  logic [IDX_W-1:0]     offsetQ;

  irq_resolver_datapath #(.NUM_LINES(NUM_LINES)) u_dp (
    .clk(clk), .rst(rst), .reqIn(reqIn), .trigLevel(trigLevel),
    .maskWr(maskWr), .maskData(maskData), .offsetWr(offsetWr),
    .offsetData(offsetData), .ctrl(ctrl), .ackLine(winLine),
    .irrQ(irrQ), .isrQ(isrQ), .maskQ(maskQ), .offsetQ(offsetQ)
  );

  irq_resolver_control #(
    .NUM_LINES(NUM_LINES), .IS_MASTER(IS_MASTER), .CASCADE_LINE(CASCADE_LINE)
  ) u_ctl (
    .clk(clk), .rst(rst), .irrQ(irrQ), .isrQ(isrQ), .maskQ(maskQ),
    .offsetQ(offsetQ), .autoEoi(autoEoi), .rotateOnAeoi(rotateOnAeoi),
    .nestedMode(nestedMode), .ackIn(ackIn), .irqPending(irqPending),
    .winLine(winLine), .ctrl(ctrl)
  );
endmodule

// File: tb/irq_resolver_test.sv
module irq_resolver_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] reqIn = '0, trigLevel = '0, maskData = '0;
  logic maskWr = 1'b0, offsetWr = 1'b0;
  logic [2:0] offsetData = '0;
  logic autoEoi = 1'b0, rotateOnAeoi = 1'b0, nestedMode = 1'b0, ackIn = 1'b0;
  logic irqPending;
  logic [2:0] winLine;

  int nChecks = 0;
  int nFails = 0;

  // bench model state
  logic [7:0] mIrr = '0, mIsr = '0, mMask = '0, mPrev = '0;
  logic [2:0] mOff = '0;

  irq_resolver uut (
    .clk(clk), .rst(rst), .reqIn(reqIn), .trigLevel(trigLevel),
    .maskWr(maskWr), .maskData(maskData), .offsetWr(offsetWr),
    .offsetData(offsetData), .autoEoi(autoEoi), .rotateOnAeoi(rotateOnAeoi),
    .nestedMode(nestedMode), .ackIn(ackIn), .irqPending(irqPending),
    .winLine(winLine)
  );

  always #5 clk = ~clk;

  // {pending, line} from model state
  function automatic logic [3:0] mdlWinner();
    logic [7:0] cand, isrV;
    int rBest, iBest;
    cand = mIrr & ~mMask;
    isrV = nestedMode ? (mIsr & 8'hFB) : mIsr;
    rBest = 8; iBest = 8;
    for (int p = 0; p < 8; p++) begin
      if (rBest == 8 && cand[(p + mOff) % 8]) rBest = p;
      if (iBest == 8 && isrV[(p + mOff) % 8]) iBest = p;
    end
    if (rBest < iBest) return {1'b1, 3'((rBest + mOff) % 8)};
    return 4'b0;
  endfunction

  function automatic void mdlStep();
    logic [3:0] w;
    logic [7:0] nIrr;
    w = mdlWinner();
    if (rst) begin
      mIrr = '0; mIsr = '0; mMask = '0; mPrev = '0; mOff = '0;
      return;
    end
    for (int i = 0; i < 8; i++) begin
      if (trigLevel[i]) nIrr[i] = reqIn[i];
      else begin
        nIrr[i] = mIrr[i];
        if (ackIn && w[3] && w[2:0] == 3'(i)) nIrr[i] = 1'b0;
        if (reqIn[i] && !mPrev[i]) nIrr[i] = 1'b1;
      end
    end
    if (offsetWr) mOff = offsetData;
    if (ackIn && w[3]) begin
      if (!autoEoi) mIsr[w[2:0]] = 1'b1;
      else if (rotateOnAeoi) mOff = w[2:0] + 3'd1;
    end
    if (maskWr) mMask = maskData;
    mIrr = nIrr;
    mPrev = reqIn;
  endfunction

  task automatic tick();
    @(posedge clk);
    mdlStep();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [3:0] expv);
    nChecks++;
    if ({irqPending, winLine} !== expv) begin
      nFails++;
      $display("FAIL %s: pending/line actual %0b/%0d expected %0b/%0d",
               tag, irqPending, winLine, expv[3], expv[2:0]);
    end
  endtask

  task automatic doReset();
    rst = 1'b1; reqIn = '0; trigLevel = '0; maskWr = 0; offsetWr = 0;
    autoEoi = 0; rotateOnAeoi = 0; nestedMode = 0; ackIn = 0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic ackPulse();
    ackIn = 1'b1; tick(); ackIn = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();
    chk("R1 reset idle", 4'b0);

    // edge line 3 with auto-EOI
    autoEoi = 1; reqIn = 8'h08; tick();
    chk("R2 rising edge", {1'b1, 3'd3});
    ackPulse();
    chk("R8 edge cleared on ack", 4'b0);
    tick();
    chk("R2 held high no retrigger", 4'b0);
    reqIn = 8'h00; tick();
    chk("R2 falling no effect", 4'b0);
    reqIn = 8'h08; tick();
    chk("R2 re-armed edge", {1'b1, 3'd3});

    // level line 5
    doReset();
    trigLevel = 8'h20; autoEoi = 1; reqIn = 8'h20; tick();
    chk("R3 level high", {1'b1, 3'd5});
    ackPulse();
    chk("R8 level kept after ack", {1'b1, 3'd5});
    reqIn = 8'h00; tick();
    chk("R3 level low clears", 4'b0);

    // mask
    reqIn = 8'h20; maskData = 8'h20; maskWr = 1; tick(); maskWr = 0;
    chk("R4 masked line", 4'b0);
    maskData = 8'h00; maskWr = 1; tick(); maskWr = 0;
    chk("R4 unmasked line", {1'b1, 3'd5});

    // rotation
    doReset();
    trigLevel = 8'hFF; reqIn = 8'h42; tick();
    chk("R5 offset 0", {1'b1, 3'd1});
    offsetData = 3'd4; offsetWr = 1; tick(); offsetWr = 0;
    chk("R5 offset 4", {1'b1, 3'd6});
    offsetData = 3'd7; offsetWr = 1; tick(); offsetWr = 0;
    chk("R5 offset 7 wrap", {1'b1, 3'd1});

    // in-service ranking
    doReset();
    trigLevel = 8'hFF; reqIn = 8'h10; tick();
    chk("R6 first request", {1'b1, 3'd4});
    ackPulse();
    chk("R6 equal slot held off", 4'b0);
    reqIn = 8'h50; tick();
    chk("R6 lower slot held off", 4'b0);
    reqIn = 8'h52; tick();
    chk("R6 higher slot wins", {1'b1, 3'd1});

    // nested mode on cascade line
    doReset();
    trigLevel = 8'hFF; reqIn = 8'h04; tick();
    ackPulse();
    chk("R7 line 2 in service", 4'b0);
    nestedMode = 1; tick();
    chk("R7 nested ignores line 2", {1'b1, 3'd2});
    nestedMode = 0; tick();
    chk("R7 nested off", 4'b0);

    // rotate on auto-EOI
    doReset();
    trigLevel = 8'hFF; autoEoi = 1; rotateOnAeoi = 1; reqIn = 8'h28; tick();
    chk("R9 before rotate", {1'b1, 3'd3});
    ackPulse();
    chk("R9 rotated to 4", {1'b1, 3'd5});
    ackPulse();
    chk("R9 rotated to 6", {1'b1, 3'd3});

    // ack with nothing pending
    doReset();
    trigLevel = 8'hFF; ackPulse();
    chk("R10 idle ack", 4'b0);
    reqIn = 8'h01; tick();
    chk("R10 no isr set", {1'b1, 3'd0});

    // seeded random traffic
    void'($urandom(32'd1234));
    doReset();
    for (int n = 0; n < 4000; n++) begin
      rst = ($urandom_range(0, 59) == 0);
      reqIn = ($urandom_range(0, 2) == 0) ? 8'($urandom()) : reqIn;
      if ($urandom_range(0, 15) == 0) trigLevel = 8'($urandom());
      maskWr = ($urandom_range(0, 7) == 0);
      maskData = 8'($urandom()) & 8'($urandom());
      offsetWr = ($urandom_range(0, 7) == 0);
      offsetData = 3'($urandom());
      if ($urandom_range(0, 15) == 0) autoEoi = 1'($urandom());
      if ($urandom_range(0, 15) == 0) rotateOnAeoi = 1'($urandom());
      if ($urandom_range(0, 15) == 0) nestedMode = 1'($urandom());
      ackIn = ($urandom_range(0, 2) == 0);
      tick();
      chk("R5 random vs model", mdlWinner());
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule